// File: doc/BRIEF.md
# Display Identification Mode Switch Controller

This block decides how a display-identification memory talks to its host. After reset it is in transmit-only mode. In that mode it streams stored bytes on SDA, one bit for each rising edge of a dedicated clock input, VCLK. It starts at byte 0, and SCL plays no part in it.

A valid falling edge on SCL while SDA is high moves the block into a tentative bidirectional mode. In that mode it watches the bus for a START followed by a slave address. It also counts VCLK rising edges. If the count reaches the timeout before an address with the right device code has been acknowledged, the block drops back to transmit-only streaming. Every SCL falling edge restarts that count.

When the upper four bits of an address byte match the device code, the block drives the acknowledge itself and locks into bidirectional mode. Only reset undoes the lock. A mode flag and an engine enable hand the bus over to a separate command engine. All inputs are oversampled on the system clock through two-flop synchronizers, and edges are taken from the synchronized copies.

Top module: `ddc_mode_ctrl`

## Requirements
- R1: After reset the block is in transmit-only mode with the following outputs: `mode` = 0, `engine_en` = 0, `sda_oe` = 0 and `mem_addr` = 0.
- R2: In transmit-only mode, a synchronized SCL falling edge seen while SDA reads high moves `mode` to 1 (tentative). While `mode` is 1, `sda_oe` stays 0. Locked mode (2) is never entered directly from transmit-only mode.
- R3: Transmit-only output uses a frame of nine slots per byte, and each VCLK rising edge advances one slot. The first rising edge after entry presents bit 7 of the byte at address 0. Slots 0 to 7 drive `sda_oe` = 1 with `sda_o` = bit 7 down to bit 0, most significant bit first. Slot 8 releases the line (`sda_oe` = 0). The address then increments and wraps from 2^ADDR_W-1 to 0.
- R4: In tentative mode each VCLK rising edge increments a counter, and each SCL falling edge clears it. The TIMEOUT-th (128th) rising edge without an intervening SCL fall returns `mode` to 0 with `sda_oe` = 0 and `mem_addr` = 0. The next rising edge drives bit 7 of byte 0.
- R5: In tentative mode, after a START and eight address bits whose upper four bits equal 1010 (DEV_CODE), the falling SCL edge that follows the eighth bit sets `mode` to 2. It also drives the acknowledge (`sda_oe` = 1, `sda_o` = 0) until the next SCL falling edge. The lower four address bits are ignored. Once `mode` is 2, VCLK no longer affects it and only reset clears it.
- R6: An address byte whose upper four bits differ from 1010 receives no acknowledge (`sda_oe` stays 0). `mode` stays 1, and the timeout of R4 still applies.
- R7: A STOP (SDA rising while SCL is high) during the address phase abandons the address. `mode` stays 1, and the timeout of R4 still returns the block to mode 0.
- R8: The `mode` encoding is 0 for transmit-only, 1 for tentative and 2 for locked. `engine_en` is 1 only in mode 2. An SCL falling edge while SDA is low, or any SCL rising edge, leaves transmit-only mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| vclk | input | 1 | Dedicated streaming clock (asynchronous) |
| scl | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Output enable for the data line |
| sda_o | output | 1 | Value driven on the data line when enabled |
| mem_addr | output | ADDR_W | Read address to the identification array |
| mem_data | input | 8 | Read data, combinational from `mem_addr` |
| mode | output | 2 | 0 transmit-only, 1 tentative, 2 locked |
| engine_en | output | 1 | Enables the external command engine |

## Verification
The assertions assume that VCLK, SCL and SDA each stay stable for several system clocks between changes. A rising VCLK edge is assumed never to land in the same synchronized sample as an SCL falling edge. SDA is assumed to change only while SCL is low, except when a START or STOP is intended. The bench steps every input through tasks that hold each level for six system clocks. It never moves two lines in the same step, and it models the bus so that the device's drive overrides the host whenever `sda_oe` is high.

// File: rtl/ddc_mode_ctrl.sv
module ddc_mode_ctrl #(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned TIMEOUT  = 128,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vclk,
  input  logic              scl,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              sda_o,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_data,
  output logic [1:0]        mode,
  output logic              engine_en
);

  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [1:0] M_XMIT = 2'd0;
  localparam logic [1:0] M_TENT = 2'd1;
  localparam logic [1:0] M_LOCK = 2'd2;
  localparam logic [1:0] P_IDLE  = 2'd0;
  localparam logic [1:0] P_SHIFT = 2'd1;
  localparam logic [1:0] P_ACK   = 2'd2;

  logic [2:0] vclk_sy, scl_sy, sda_sy;
  logic [CW-1:0] vcnt;
  logic [ADDR_W-1:0] addr;
  logic [3:0] slot;
  logic started;
  logic [1:0] ph;
  logic [3:0] bitcnt;
  logic [7:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vclk_sy <= 3'b000;
      scl_sy  <= 3'b111;
      sda_sy  <= 3'b111;
    end else begin
      vclk_sy <= {vclk_sy[1:0], vclk};
      scl_sy  <= {scl_sy[1:0], scl};
      sda_sy  <= {sda_sy[1:0], sda_i};
    end
  end

  wire v_rise   = vclk_sy[1] & ~vclk_sy[2];
  wire scl_hi   = scl_sy[1];
  wire sda_hi   = sda_sy[1];
  wire scl_fall = ~scl_sy[1] & scl_sy[2];
  wire scl_rise = scl_sy[1] & ~scl_sy[2];
  wire sda_fall = ~sda_sy[1] & sda_sy[2];
  wire sda_rise = sda_sy[1] & ~sda_sy[2];
  wire start_c  = sda_fall & scl_hi & scl_sy[2];
  wire stop_c   = sda_rise & scl_hi & scl_sy[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= M_XMIT;
      vcnt    <= '0;
      addr    <= '0;
      slot    <= 4'd0;
      started <= 1'b0;
      ph      <= P_IDLE;
      bitcnt  <= 4'd0;
      shreg   <= 8'd0;
    end else begin
      case (mode)
        M_XMIT: begin
          if (scl_fall && sda_hi) begin
            mode <= M_TENT;
            vcnt <= '0;
            ph   <= P_IDLE;
          end else if (v_rise) begin
            if (!started) begin
              started <= 1'b1;
              slot    <= 4'd0;
              addr    <= '0;
            end else if (slot == 4'd8) begin
              slot <= 4'd0;
              addr <= addr + 1'b1;
            end else begin
              slot <= slot + 4'd1;
            end
          end
        end
        M_TENT: begin
          if (scl_fall) begin
            vcnt <= '0;
          end else if (v_rise) begin
            if (vcnt == CW'(TIMEOUT - 1)) begin
              mode    <= M_XMIT;
              started <= 1'b0;
              addr    <= '0;
              slot    <= 4'd0;
              vcnt    <= '0;
            end else begin
              vcnt <= vcnt + 1'b1;
            end
          end
          if (start_c) begin
            ph     <= P_SHIFT;
            bitcnt <= 4'd0;
          end else if (stop_c) begin
            ph <= P_IDLE;
          end else if (ph == P_SHIFT && scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_hi};
            bitcnt <= bitcnt + 4'd1;
          end else if (ph == P_SHIFT && scl_fall && bitcnt == 4'd8) begin
            if (shreg[7:4] == DEV_CODE) begin
              ph   <= P_ACK;
              mode <= M_LOCK;
            end else begin
              ph <= P_IDLE;
            end
          end
        end
        default: begin
          if (ph == P_ACK && scl_fall) ph <= P_IDLE;
        end
      endcase
    end
  end

  wire xmit_drive = (mode == M_XMIT) && started && (slot != 4'd8);
  wire ack_drive  = (ph == P_ACK);

  assign sda_oe    = xmit_drive | ack_drive;
  assign sda_o     = ack_drive ? 1'b0 : mem_data[~slot[2:0]];
  assign mem_addr  = addr;
  assign engine_en = (mode == M_LOCK);

endmodule

// File: rtl/ddc_mode_ctrl_sva.sv
module ddc_mode_ctrl_sva #(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned TIMEOUT = 128,
  parameter int unsigned CW      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              sda_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CW-1:0]     vcnt
);

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) mode != 2'd3); // R8
  AST_TENT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd1) |-> !sda_oe); // R2
  AST_XMIT_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd0) |=> (mode != 2'd2)); // R2
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd2) |=> (mode == 2'd2)); // R5
  AST_LOCK_FROM_TENT: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd2 && $past(mode) != 2'd2) |-> ($past(mode) == 2'd1)); // R5
  AST_REVERT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd0 && $past(mode) == 2'd1) |-> (mem_addr == '0 && !sda_oe)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) vcnt < CW'(TIMEOUT)); // R4

endmodule

bind ddc_mode_ctrl ddc_mode_ctrl_sva #(
  .ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT), .CW(CW)
) u_sva (
  .clk(clk), .rst_n(rst_n), .mode(mode), .sda_oe(sda_oe),
  .mem_addr(mem_addr), .vcnt(vcnt)
);

// File: tb/ddc_mode_ctrl_tb.sv
module ddc_mode_ctrl_tb;
  localparam int AW = 7;
  localparam int DEPTH = 1 << AW;
  localparam int TO = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vclk = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_oe, sda_o, engine_en;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;
  logic [1:0] mode;
  logic sda_bus;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] exp_byte(int a);
    return 8'((a * 37 + 91) & 255);
  endfunction

  assign mem_data = exp_byte(int'(mem_addr));
  assign sda_bus  = sda_oe ? sda_o : host_sda;

  ddc_mode_ctrl #(.ADDR_W(AW), .TIMEOUT(TO), .DEV_CODE(4'b1010)) u_dut (
    .clk(clk), .rst_n(rst_n), .vclk(vclk), .scl(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .sda_o(sda_o), .mem_addr(mem_addr), .mem_data(mem_data),
    .mode(mode), .engine_en(engine_en)
  );

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic vpulse();
    vclk = 1'b1; wt(6);
    vclk = 1'b0; wt(6);
  endtask

  task automatic scl_set(logic v);
    scl = v; wt(6);
  endtask

  task automatic sda_set(logic v);
    host_sda = v; wt(6);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vclk = 1'b0; scl = 1'b1; host_sda = 1'b1;
    wt(4);
    rst_n = 1'b1;
    wt(4);
  endtask

  task automatic bus_start();
    sda_set(1'b1); scl_set(1'b1); sda_set(1'b0); scl_set(1'b0);
  endtask

  task automatic bus_stop();
    sda_set(1'b0); scl_set(1'b1); sda_set(1'b1);
  endtask

  task automatic send_bit(logic b);
    sda_set(b); scl_set(1'b1); scl_set(1'b0);
  endtask

  task automatic enter_tent();
    scl_set(1'b1); scl_set(1'b0);
  endtask

  initial begin
    while (cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [7:0] abyte;
    do_reset();
    chk("R1 mode", int'(mode), 0);
    chk("R1 engine_en", int'(engine_en), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 mem_addr", int'(mem_addr), 0);

    sda_set(1'b0); scl_set(1'b0);
    chk("R8 fall with sda low", int'(mode), 0);
    sda_set(1'b1); scl_set(1'b1);
    chk("R8 scl rise ignored", int'(mode), 0);

    for (int k = 0; k <= DEPTH; k++) begin
      b = exp_byte(k % DEPTH);
      for (int s = 0; s < 9; s++) begin
        vpulse();
        if (s == 0) chk("R3 address", int'(mem_addr), k % DEPTH);
        if (s < 8) chk("R3 data slot", int'({sda_oe, sda_o}), int'({1'b1, b[7-s]}));
        else chk("R3 release slot", int'(sda_oe), 0);
      end
    end
    chk("R3 still xmit", int'(mode), 0);

    scl_set(1'b0);
    chk("R2 tentative", int'(mode), 1);
    chk("R2 released", int'(sda_oe), 0);
    repeat (TO - 1) vpulse();
    chk("R4 before limit", int'(mode), 1);
    enter_tent();
    repeat (TO - 1) vpulse();
    chk("R4 cleared by scl fall", int'(mode), 1);
    vpulse();
    chk("R4 reverted", int'(mode), 0);
    chk("R4 released on revert", int'(sda_oe), 0);
    chk("R4 address zero", int'(mem_addr), 0);
    b = exp_byte(0);
    for (int s = 0; s < 9; s++) begin
      vpulse();
      if (s < 8) chk("R4 restart byte 0", int'({sda_oe, sda_o}), int'({1'b1, b[7-s]}));
      else chk("R4 restart release", int'(sda_oe), 0);
    end

    do_reset();
    enter_tent();
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    chk("R7 after stop", int'(mode), 1);
    repeat (TO - 1) vpulse();
    chk("R7 waiting", int'(mode), 1);
    vpulse();
    chk("R7 reverted", int'(mode), 0);

    for (int c = 0; c < 16; c++) begin
      do_reset();
      enter_tent();
      chk("R2 enter", int'(mode), 1);
      bus_start();
      abyte = {4'(c), 3'(c), 1'(c)};
      for (int i = 7; i >= 0; i--) send_bit(abyte[i]);
      if (c == 10) begin
        chk("R5 ack drive", int'({sda_oe, sda_o}), 2);
        chk("R5 locked", int'(mode), 2);
      end else begin
        chk("R6 no ack", int'(sda_oe), 0);
        chk("R6 stays tentative", int'(mode), 1);
      end
      sda_set(1'b1); scl_set(1'b1);
      if (c == 10) chk("R5 ack held", int'({sda_oe, sda_o}), 2);
      scl_set(1'b0);
      chk("R5 R6 released after ninth", int'(sda_oe), 0);
      if (c == 10) begin
        repeat (TO + 72) vpulse();
        chk("R5 lock permanent", int'(mode), 2);
        chk("R5 no stream", int'(sda_oe), 0);
        chk("R8 engine_en", int'(engine_en), 1);
      end else begin
        bus_stop();
        repeat (TO - 1) vpulse();
        chk("R6 before timeout", int'(mode), 1);
        vpulse();
        chk("R6 timeout", int'(mode), 0);
        chk("R8 engine off", int'(engine_en), 0);
      end
    end

    do_reset();
    chk("R1 reset clears lock", int'(mode), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule